// File: doc/BRIEF.md
# Fixed-Priority Spike Fan-Out Arbiter

This block sits between one layer of integrate-and-fire neurons and the next layer. Each neuron of the source layer raises a request line when it fires. The block serves one requester at a time in fixed priority order. For the chosen neuron it reads that neuron's row of binary synaptic weights from a local single-port store. Each weight bit becomes a one-cycle spike on one output column: an increment spike for a positive weight, a decrement spike for a negative one. It then acknowledges the served neuron.

Only one row is broadcast per service. The column outputs can therefore run as plain wires to the post-synaptic neurons, and no input ever receives two spikes at once. A clock-enable output tells the local clock source to run while any request is present or a service is in progress, so that the block is idle and gated when the layer is silent. A write port loads weight rows. It takes effect only while the arbiter is idle.

Top module: `spike_fanout_arb`

## Requirements
- R1: After reset, every acknowledge bit, every increment and decrement spike line, and the clock-enable are low while no request is asserted.
- R2: The clock-enable is high in every cycle in which any request bit is high or a service is in progress, and low once the block is idle with no request asserted.
- R3: When several eligible requests are pending at a decision point, the one with the lowest bit index is served first (bit 0 has the highest priority).
- R4: A service takes one cycle each for grant, memory read, spike pulse and acknowledge. In the pulse cycle, column c carries an increment spike if bit c of the served row is 1 (+1), and a decrement spike if it is 0 (−1).
- R5: No column ever carries an increment and a decrement spike in the same cycle, and all spike lines are low outside the pulse cycle.
- R6: The served neuron's acknowledge bit rises in the cycle after the pulse. It stays high while that request stays high and falls in the cycle after the request falls. At most one acknowledge bit rises per cycle.
- R7: A request whose acknowledge is still high is not served again until the request has been dropped and raised anew.
- R8: If another eligible request is pending in the acknowledge cycle, its grant follows at once without an idle cycle, so back-to-back services start four cycles apart.
- R9: A weight write presented while a service is in progress (grant, read, pulse or acknowledge cycle) is discarded.
- R10: A weight write presented while the arbiter is idle updates the addressed row. This includes the idle cycle in which a grant is taken. The next service of that row uses the new value.
- R11: Under sustained load from higher-priority requesters, a lower-priority request waits without being served. It is served once that load stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_REQ | Firing requests, one per source neuron |
| ack_o | output | N_REQ | Acknowledge, one per source neuron |
| wr_en_i | input | 1 | Weight row write strobe |
| wr_row_i | input | IDX_W | Row (source neuron) to write |
| wr_data_i | input | N_COL | Row weights, 1 = +1, 0 = −1 |
| spk_inc_o | output | N_COL | Increment spike per post-synaptic column |
| spk_dec_o | output | N_COL | Decrement spike per post-synaptic column |
| clk_en_o | output | 1 | Local clock-enable request |

## Verification
The bench raises several requests at once. It checks that acknowledges come back in ascending index order, four cycles apart. A priority encoder that scanned from the wrong end, or an arbiter that went idle between services, would scramble that order or stretch the spacing. A requester that holds its line after being acknowledged must not be served twice. A write aimed at a row while a service is in flight must leave the old weights in the next pulse, and an idle write must show up in it. A design that took writes at any time, or that regranted a held request, would emit wrong spikes or a second acknowledge. Two high-priority requesters re-fire continuously to show that a low-priority request is starved and is then served once that load stops. A reference weight table catches any column whose polarity is inverted or shifted.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GRANT,
      ST_READ,
      ST_SPIKE,
      ST_ACK
   } sfa_state_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sfa_prio_pick.sv
module sfa_prio_pick #(
   parameter int unsigned WIDTH         = 256,
   parameter bit          ISOLATE_STYLE = 1'b0,
   localparam int unsigned IW           = sfa_pkg::idx_width(WIDTH)
) (
   input  logic [WIDTH-1:0] cand_i,
   output logic             found_o,
   output logic [IW-1:0]    idx_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("sfa_prio_pick: WIDTH must be at least 1");
      end
   endgenerate

   assign found_o = |cand_i;

   generate
      if (ISOLATE_STYLE) begin : g_isolate
         logic [WIDTH-1:0] lowest;
         assign lowest = cand_i & (~cand_i + WIDTH'(1));
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < int'(WIDTH); i++) begin
               if (lowest[i]) idx_o = idx_o | IW'(i);
            end
         end
      end else begin : g_scan
         always_comb begin
            idx_o = '0;
            for (int i = int'(WIDTH) - 1; i >= 0; i--) begin
               if (cand_i[i]) idx_o = IW'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sfa_weight_store.sv
module sfa_weight_store #(
   parameter int unsigned ROWS = 256,
   parameter int unsigned COLS = 128,
   localparam int unsigned AW  = sfa_pkg::idx_width(ROWS)
) (
   input  logic            clk,
   input  logic            wr_en_i,
   input  logic [AW-1:0]   wr_row_i,
   input  logic [COLS-1:0] wr_data_i,
   input  logic            rd_en_i,
   input  logic [AW-1:0]   rd_row_i,
   output logic [COLS-1:0] rd_data_o
);

   generate
      if (ROWS < 1 || COLS < 1) begin : g_bad_shape
         $error("sfa_weight_store: ROWS and COLS must be at least 1");
      end
   endgenerate

   logic [COLS-1:0] mem_q [ROWS];
   logic            wr_in_range;

   assign wr_in_range = (32'(wr_row_i) < ROWS);

   always_ff @(posedge clk) begin
      if (wr_en_i && wr_in_range) mem_q[wr_row_i] <= wr_data_i;
   end

   always_ff @(posedge clk) begin
      if (rd_en_i) rd_data_o <= mem_q[rd_row_i];
   end

endmodule

// File: rtl/sfa_spike_drive.sv
module sfa_spike_drive #(
   parameter int unsigned COLS       = 128,
   parameter bit          ONE_IS_INC = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire_i,
   input  logic [COLS-1:0] row_i,
   output logic [COLS-1:0] inc_o,
   output logic [COLS-1:0] dec_o
);

   logic [COLS-1:0] pos_w;

   generate
      if (ONE_IS_INC) begin : g_one_pos
         assign pos_w = row_i;
      end else begin : g_zero_pos
         assign pos_w = ~row_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inc_o <= '0;
         dec_o <= '0;
      end else if (fire_i) begin
         inc_o <= pos_w;
         dec_o <= ~pos_w;
      end else begin
         inc_o <= '0;
         dec_o <= '0;
      end
   end

endmodule

// File: rtl/spike_fanout_arb.sv
module spike_fanout_arb #(
   parameter int unsigned N_REQ        = 256,
   parameter int unsigned N_COL        = 128,
   parameter bit          PICK_ISOLATE = 1'b0,
   parameter bit          ONE_IS_INC   = 1'b1,
   localparam int unsigned IDX_W       = sfa_pkg::idx_width(N_REQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req_i,
   output logic [N_REQ-1:0] ack_o,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_row_i,
   input  logic [N_COL-1:0] wr_data_i,
   output logic [N_COL-1:0] spk_inc_o,
   output logic [N_COL-1:0] spk_dec_o,
   output logic             clk_en_o
);

   import sfa_pkg::*;

   generate
      if (N_REQ < 1) begin : g_bad_req
         $error("spike_fanout_arb: N_REQ must be at least 1");
      end
      if (N_COL < 1) begin : g_bad_col
         $error("spike_fanout_arb: N_COL must be at least 1");
      end
   endgenerate

   sfa_state_e       state_q, state_d;
   logic [IDX_W-1:0] idx_q;
   logic [N_REQ-1:0] ack_q, ack_set;
   logic [N_REQ-1:0] eligible;
   logic             pick_found;
   logic [IDX_W-1:0] pick_idx;
   logic             decide;
   logic [N_COL-1:0] row_data;
   logic             wr_accept;

   // Requests already acknowledged stay blocked until they drop.
   assign eligible = req_i & ~ack_q;

   sfa_prio_pick #(
      .WIDTH         (N_REQ),
      .ISOLATE_STYLE (PICK_ISOLATE)
   ) u_pick (
      .cand_i  (eligible),
      .found_o (pick_found),
      .idx_o   (pick_idx)
   );

   assign decide = (state_q == ST_IDLE) || (state_q == ST_ACK);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (pick_found) state_d = ST_GRANT;
         ST_GRANT: state_d = ST_READ;
         ST_READ:  state_d = ST_SPIKE;
         ST_SPIKE: state_d = ST_ACK;
         ST_ACK:   state_d = pick_found ? ST_GRANT : ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         if (decide && pick_found) idx_q <= pick_idx;
      end
   end

   assign ack_set = (state_q == ST_SPIKE) ? (N_REQ'(1) << idx_q) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= '0;
      else        ack_q <= (ack_q & req_i) | ack_set;
   end

   assign wr_accept = wr_en_i && (state_q == ST_IDLE);

   sfa_weight_store #(
      .ROWS (N_REQ),
      .COLS (N_COL)
   ) u_store (
      .clk       (clk),
      .wr_en_i   (wr_accept),
      .wr_row_i  (wr_row_i),
      .wr_data_i (wr_data_i),
      .rd_en_i   (state_q == ST_GRANT),
      .rd_row_i  (idx_q),
      .rd_data_o (row_data)
   );

   sfa_spike_drive #(
      .COLS       (N_COL),
      .ONE_IS_INC (ONE_IS_INC)
   ) u_drive (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (state_q == ST_READ),
      .row_i  (row_data),
      .inc_o  (spk_inc_o),
      .dec_o  (spk_dec_o)
   );

   assign ack_o    = ack_q;
   assign clk_en_o = (state_q != ST_IDLE) || (|req_i);

endmodule

// File: rtl/sfa_checker.sv
module sfa_checker #(
   parameter int unsigned N_REQ = 256,
   parameter int unsigned N_COL = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_REQ-1:0] req_i,
   input logic [N_REQ-1:0] ack_o,
   input logic [N_COL-1:0] spk_inc_o,
   input logic [N_COL-1:0] spk_dec_o,
   input logic             clk_en_o
);

   // R5
   no_dual_spike_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spk_inc_o & spk_dec_o) == '0);

   // R4
   spike_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(spk_inc_o | spk_dec_o)) |=> ((spk_inc_o | spk_dec_o) == '0));

   // R4
   spike_full_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(spk_inc_o | spk_dec_o)) |-> (&(spk_inc_o | spk_dec_o)));

   // R6
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((($past(ack_o) & $past(req_i)) & ~ack_o)) == '0));

   // R6
   ack_one_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $onehot0(ack_o & ~$past(ack_o)));

   // R6
   ack_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(spk_inc_o | spk_dec_o)) |=> (|(ack_o & ~$past(ack_o))));

   // R2
   clk_en_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_i) |-> clk_en_o);

endmodule

bind spike_fanout_arb sfa_checker #(
   .N_REQ (N_REQ),
   .N_COL (N_COL)
) u_sfa_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_i     (req_i),
   .ack_o     (ack_o),
   .spk_inc_o (spk_inc_o),
   .spk_dec_o (spk_dec_o),
   .clk_en_o  (clk_en_o)
);

// File: tb/spike_fanout_arb_bench.sv
module spike_fanout_arb_bench;

   localparam int NR = 16;
   localparam int NC = 12;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NR-1:0] req = '0;
   logic [NR-1:0] ack;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_row = '0;
   logic [NC-1:0] wr_data = '0;
   logic [NC-1:0] spk_inc, spk_dec;
   logic          clk_en;

   always #4 clk = ~clk;

   spike_fanout_arb #(.N_REQ(NR), .N_COL(NC)) u_spike_fanout_arb (
      .clk(clk), .rst_n(rst_n), .req_i(req), .ack_o(ack),
      .wr_en_i(wr_en), .wr_row_i(wr_row), .wr_data_i(wr_data),
      .spk_inc_o(spk_inc), .spk_dec_o(spk_dec), .clk_en_o(clk_en)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   // Reference model state: phase 0 idle, 1 grant, 2 read, 3 pulse, 4 ack.
   int            m_phase = 0;
   int            m_idx = 0;
   logic [NR-1:0] m_ack = '0;
   logic [NC-1:0] m_mem [NR];
   logic [NC-1:0] ref_w [NR];

   logic [NR-1:0] drop_on = '1;
   logic [NR-1:0] rearm_on = '0;
   logic [NR-1:0] ack_prev = '0;
   logic [NC-1:0] last_inc = '0;
   int            served_q[$];
   int            rise_cyc[$];

   always @(posedge clk) begin
      int            pick;
      logic [NR-1:0] set;
      pick = -1;
      set  = '0;
      if (!rst_n) begin
         m_phase = 0;
         m_ack   = '0;
      end else begin
         if (wr_en && m_phase == 0) m_mem[wr_row] = wr_data;
         if (m_phase == 0 || m_phase == 4)
            for (int i = NR - 1; i >= 0; i--) if (req[i] && !m_ack[i]) pick = i;
         if (m_phase == 3) set[m_idx] = 1'b1;
         case (m_phase)
            0: if (pick >= 0) begin m_phase = 1; m_idx = pick; end
            1: m_phase = 2;
            2: m_phase = 3;
            3: m_phase = 4;
            default: if (pick >= 0) begin m_phase = 1; m_idx = pick; end
                     else m_phase = 0;
         endcase
         m_ack = (m_ack & req) | set;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   task automatic tick();
      logic [NC-1:0] e_inc, e_dec;
      @(negedge clk);
      cyc++;
      if (rst_n) begin
         e_inc = (m_phase == 3) ? m_mem[m_idx] : '0;
         e_dec = (m_phase == 3) ? ~m_mem[m_idx] : '0;
         chk(clk_en === ((m_phase != 0) || (|req)), "R2", "clk_en", 32'(clk_en),
             32'((m_phase != 0) || (|req)));
         chk(spk_inc === e_inc, "R4", "spk_inc", 32'(spk_inc), 32'(e_inc));
         chk(spk_dec === e_dec, "R4", "spk_dec", 32'(spk_dec), 32'(e_dec));
         chk((spk_inc & spk_dec) == '0, "R5", "inc/dec overlap", 32'(spk_inc & spk_dec), 0);
         chk(ack === m_ack, "R6", "ack", 32'(ack), 32'(m_ack));
      end
      for (int i = 0; i < NR; i++) begin
         if (ack[i] && !ack_prev[i]) begin
            served_q.push_back(i);
            rise_cyc.push_back(cyc);
         end
      end
      ack_prev = ack;
      if (|(spk_inc | spk_dec)) last_inc = spk_inc;
      for (int i = 0; i < NR; i++) begin
         if (req[i] && ack[i] && drop_on[i]) req[i] = 1'b0;
         else if (!req[i] && !ack[i] && rearm_on[i]) req[i] = 1'b1;
      end
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   task automatic clear_log();
      served_q.delete();
      rise_cyc.delete();
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      int cnt5, cnt0, cnt1, cnt3;
      logic [NC-1:0] new_w;

      run(3);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(ack == '0, "R1", "ack after reset", 32'(ack), 0);
      chk(spk_inc == '0 && spk_dec == '0, "R1", "spikes after reset",
          32'(spk_inc | spk_dec), 0);
      chk(clk_en == 1'b0, "R1", "clk_en after reset", 32'(clk_en), 0);

      // load weight table
      for (int r = 0; r < NR; r++) begin
         ref_w[r] = NC'((r * 37 + 5) ^ (r * 300));
         wr_en = 1'b1; wr_row = IW'(r); wr_data = ref_w[r];
         tick();
      end
      wr_en = 1'b0;

      // single request, per-column polarity
      clear_log();
      req[6] = 1'b1;
      run(10);
      chk(served_q.size() == 1 && served_q[0] == 6, "R4", "single service id",
          32'(served_q.size()), 1);
      chk(last_inc == ref_w[6], "R4", "row 6 polarity", 32'(last_inc), 32'(ref_w[6]));
      chk(clk_en == 1'b0, "R2", "clk_en idle after service", 32'(clk_en), 0);

      // simultaneous requests: ascending order, back to back
      clear_log();
      req = 16'b1010_0100_1001_0010;
      run(40);
      chk(served_q.size() == 6, "R3", "count served", 32'(served_q.size()), 6);
      for (int k = 1; k < served_q.size(); k++) begin
         chk(served_q[k] > served_q[k-1], "R3", "ascending grant order",
             32'(served_q[k]), 32'(served_q[k-1]));
         chk(rise_cyc[k] - rise_cyc[k-1] == 4, "R8", "service spacing",
             32'(rise_cyc[k] - rise_cyc[k-1]), 4);
      end
      chk(last_inc == ref_w[15], "R4", "last row polarity", 32'(last_inc), 32'(ref_w[15]));

      // held request is not regranted
      clear_log();
      drop_on[3] = 1'b0;
      req[3] = 1'b1;
      run(24);
      cnt3 = 0;
      foreach (served_q[k]) if (served_q[k] == 3) cnt3++;
      chk(cnt3 == 1, "R7", "held request served once", 32'(cnt3), 1);
      chk(ack[3] == 1'b1, "R6", "ack held with request", 32'(ack[3]), 1);
      req[3] = 1'b0;
      drop_on[3] = 1'b1;
      run(2);
      chk(ack[3] == 1'b0, "R6", "ack released", 32'(ack[3]), 0);

      // write during busy is discarded
      new_w = ~ref_w[9];
      req[2] = 1'b1;
      tick();
      wr_en = 1'b1; wr_row = 4'd9; wr_data = new_w;
      tick();
      wr_en = 1'b0;
      run(8);
      req[9] = 1'b1;
      run(8);
      chk(last_inc == ref_w[9], "R9", "busy write ignored", 32'(last_inc), 32'(ref_w[9]));

      // idle write is used by next service
      wr_en = 1'b1; wr_row = 4'd9; wr_data = new_w;
      tick();
      wr_en = 1'b0;
      ref_w[9] = new_w;
      req[9] = 1'b1;
      run(8);
      chk(last_inc == ref_w[9], "R10", "idle write visible", 32'(last_inc), 32'(ref_w[9]));

      // starvation under sustained higher-priority load
      clear_log();
      rearm_on[0] = 1'b1; rearm_on[1] = 1'b1;
      req[0] = 1'b1; req[1] = 1'b1; req[5] = 1'b1;
      run(60);
      cnt0 = 0; cnt1 = 0; cnt5 = 0;
      foreach (served_q[k]) begin
         if (served_q[k] == 0) cnt0++;
         if (served_q[k] == 1) cnt1++;
         if (served_q[k] == 5) cnt5++;
      end
      chk(cnt5 == 0, "R11", "low priority starved", 32'(cnt5), 0);
      chk(cnt0 >= 5 && cnt1 >= 5, "R11", "high priority load served",
          32'(cnt0 + cnt1), 10);
      rearm_on = '0;
      clear_log();
      run(30);
      cnt5 = 0;
      foreach (served_q[k]) if (served_q[k] == 5) cnt5++;
      chk(cnt5 == 1, "R11", "low priority served after load", 32'(cnt5), 1);
      chk(clk_en == 1'b0, "R2", "clk_en low at end", 32'(clk_en), 0);

      finish_up();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      finish_up();
   end

endmodule